// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns characters held in a short queue into frames on one serial output line. A one-cycle clock enable that fires sixteen times per bit period paces the serializer, so each bit occupies sixteen of these ticks. Every frame has a low start bit, then 5 to 12 data bits with the least significant bit first, then an optional parity bit, then a high stop period. The stop period lasts until the frame's tick counter reaches a precomputed last-tick value.

The host pushes characters with a one-cycle write strobe and supplies the frame format. The format is the word length, a 3-bit parity mode and the index of the last tick of the frame. That index is (1 + word length + parity bit) x 16 + stop length in half bits x 8, minus one. So 2, 3 and 4 half bits give one, one and a half and two stop bits. A clear-to-send input gates the start of new frames, and a break input holds the line low. The queue can be shrunk to a single holding register or emptied with a clear pulse. Full, empty and the occupancy are reported at all times.

Top module: `serial_tx`

## Requirements
- R1: After reset the line is high, the queue is empty (empty=1, full=0, count=0), and the line stays high whenever no frame is in progress and no break is requested.
- R2: A frame starts only on a cycle with tick16=1 and no frame in progress, while the queue holds a character, cts=1, brk=0 and q_clear=0. The start tick drives the line low, and each further tick16 pulse advances the in-frame tick counter by one. Bit index is the tick counter divided by 16.
- R3: Bit indices 1 to word_len carry the character's data bits, least significant first. word_len is the plain binary bit count, 5 to 12.
- R4: parity_mode bit 0 enables a parity bit at index word_len+1. Bits [2:1] choose its value: 00 odd (data plus parity has an odd number of ones), 01 even, 10 always 1, 11 always 0. Mode 000 sends no parity bit.
- R5: Every index after the data and parity bits is high (stop). The frame ends on the tick16 pulse where the tick counter equals frame_last, and the line then stays high for at least one tick before the next start.
- R6: With cts=0 no new frame begins. A frame already in progress runs to its end.
- R7: While brk=1 the line is held low on every cycle and no new frame begins. A frame in progress keeps its timing underneath the break.
- R8: With q_enable=1 the queue holds DEPTH characters in order. full=1 at DEPTH entries, and a write while full is dropped without changing the count.
- R9: With q_enable=0 the queue acts as one holding register. full=1 once one character is held, and further writes are dropped.
- R10: A q_clear pulse empties the queue (count=0 on the next cycle) and has priority over a write or a frame start in the same cycle.
- R11: count equals the number of characters held. It rises by one on an accepted write, falls by one when a frame starts, and is unchanged when both happen in one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | One-cycle enable at 16x the bit rate |
| wr_en | input | 1 | Write strobe for one character |
| wr_data | input | 12 | Character to queue; bits above word_len are ignored |
| q_enable | input | 1 | 1 = multi-entry queue, 0 = single holding register |
| q_clear | input | 1 | Empties the queue |
| cts | input | 1 | Clear to send, active high |
| brk | input | 1 | Break request: line forced low |
| word_len | input | 4 | Data bits per character, 5 to 12 |
| parity_mode | input | 3 | Parity selection code |
| frame_last | input | 9 | Index of the last tick of a frame |
| txd | output | 1 | Serial line, idle high |
| full | output | 1 | Queue cannot accept another character |
| empty | output | 1 | Queue holds no character |
| count | output | 4 | Characters currently held |

## Verification
The hardest cases to reach from the ports are a clear-to-send drop or a break that lands in the middle of a frame. The frame must keep its tick count through either. They also include a write that coincides with a frame start on a full queue. The stimulus holds cts low while it loads the queue, so the queue fills to capacity with nothing draining. It then releases cts and drops cts or raises brk partway through the following frame. A behavioural model of queue contents and frame position is compared against every output on every clock. That comparison catches any tick where the line, the flags or the count drift.

// File: rtl/serial_tx_pkg.sv
`timescale 1ns/1ps
package serial_tx_pkg;

    localparam int MAX_BITS = 12;
    localparam int FRAME_W  = 9;
    localparam int IDX_W    = FRAME_W - 4;

    typedef logic [MAX_BITS-1:0] char_t;

    typedef enum logic [1:0] {
        PAR_ODD   = 2'b00,
        PAR_EVEN  = 2'b01,
        PAR_MARK  = 2'b10,
        PAR_SPACE = 2'b11
    } par_kind_e;

    typedef struct packed {
        logic [3:0]         wlen;
        logic               par_on;
        par_kind_e          kind;
        logic [FRAME_W-1:0] last_tick;
    } frame_fmt_t;

    function automatic logic calc_parity(char_t d, logic [3:0] wlen, par_kind_e k);
        logic x;
        x = 1'b0;
        for (int i = 0; i < MAX_BITS; i++)
            if (i < int'(wlen)) x ^= d[i];
        case (k)
            PAR_ODD:   return ~x;
            PAR_EVEN:  return x;
            PAR_MARK:  return 1'b1;
            default:   return 1'b0;
        endcase
    endfunction

    function automatic logic frame_bit(char_t d, frame_fmt_t f, logic [IDX_W-1:0] idx);
        logic [IDX_W-1:0] w;
        w = IDX_W'(f.wlen);
        if (idx == '0)
            return 1'b0;
        else if (idx <= w)
            return d[4'(idx - 1'b1)];
        else if (f.par_on && idx == w + 1'b1)
            return calc_parity(d, f.wlen, f.kind);
        else
            return 1'b1;
    endfunction

endpackage

// File: rtl/serial_tx_queue.sv
`timescale 1ns/1ps
module serial_tx_queue
    import serial_tx_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  char_t         wr_data,
    input  logic          en,
    input  logic          clr,
    input  logic          pop,
    output char_t         head,
    output logic          full,
    output logic          empty,
    output logic [CW-1:0] count
);

    char_t         mem [DEPTH];
    logic [AW-1:0] rptr, wptr;
    logic [CW-1:0] cap;
    logic          accept;

    assign cap    = en ? CW'(DEPTH) : CW'(1);
    assign full   = count >= cap;
    assign empty  = count == '0;
    assign head   = mem[rptr];
    assign accept = wr_en && !full;

    always_ff @(posedge clk) begin
        if (accept && !clr) mem[wptr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            rptr  <= '0;
            wptr  <= '0;
            count <= '0;
        end else begin
            if (accept) wptr <= wptr + 1'b1;
            if (pop)    rptr <= rptr + 1'b1;
            case ({accept, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assert_drop_when_full_R8: assert property (@(posedge clk) disable iff (rst)
        (full && wr_en && !pop && !clr) |=> count == $past(count));
    assert_single_cap_R9: assert property (@(posedge clk) disable iff (rst)
        (!en && count == CW'(1) && wr_en && !pop && !clr) |=> count == CW'(1));
    assert_clear_empties_R10: assert property (@(posedge clk) disable iff (rst)
        clr |=> empty);
    assert_occupancy_up_R11: assert property (@(posedge clk) disable iff (rst)
        (!clr && wr_en && !full && !pop) |=> count == $past(count) + 1'b1);

endmodule

// File: rtl/serial_tx_shifter.sv
`timescale 1ns/1ps
module serial_tx_shifter
    import serial_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick16,
    input  logic       cts,
    input  logic       brk,
    input  logic       clr,
    input  logic       empty,
    input  char_t      head,
    input  frame_fmt_t fmt,
    output logic       pop,
    output logic       txd
);

    logic               busy;
    logic [FRAME_W-1:0] tcnt;
    char_t              cur;
    logic               line;

    assign pop  = !busy && tick16 && !empty && cts && !brk && !clr;
    assign line = busy ? frame_bit(cur, fmt, tcnt[FRAME_W-1:4]) : 1'b1;
    assign txd  = brk ? 1'b0 : line;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            tcnt <= '0;
            cur  <= '0;
        end else if (pop) begin
            busy <= 1'b1;
            tcnt <= '0;
            cur  <= head;
        end else if (busy && tick16) begin
            if (tcnt == fmt.last_tick) busy <= 1'b0;
            else                       tcnt <= tcnt + 1'b1;
        end
    end

    assert_tick_advance_R2: assert property (@(posedge clk) disable iff (rst)
        (busy && tick16 && tcnt != fmt.last_tick) |=> tcnt == $past(tcnt) + 1'b1);
    assert_frame_end_R5: assert property (@(posedge clk) disable iff (rst)
        (busy && tick16 && tcnt == fmt.last_tick) |=> !busy);
    assert_cts_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!busy && !cts) |=> !busy);
    assert_break_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!busy && brk) |=> !busy);

endmodule

// File: rtl/serial_tx.sv
`timescale 1ns/1ps
module serial_tx
    import serial_tx_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick16,
    input  logic          wr_en,
    input  logic [11:0]   wr_data,
    input  logic          q_enable,
    input  logic          q_clear,
    input  logic          cts,
    input  logic          brk,
    input  logic [3:0]    word_len,
    input  logic [2:0]    parity_mode,
    input  logic [8:0]    frame_last,
    output logic          txd,
    output logic          full,
    output logic          empty,
    output logic [CW-1:0] count
);

    frame_fmt_t fmt;
    char_t      head;
    logic       pop;

    assign fmt.wlen      = word_len;
    assign fmt.par_on    = parity_mode[0];
    assign fmt.kind      = par_kind_e'(parity_mode[2:1]);
    assign fmt.last_tick = frame_last;

    serial_tx_queue #(.DEPTH(DEPTH)) u_queue (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .en      (q_enable),
        .clr     (q_clear),
        .pop     (pop),
        .head    (head),
        .full    (full),
        .empty   (empty),
        .count   (count)
    );

    serial_tx_shifter u_shift (
        .clk    (clk),
        .rst    (rst),
        .tick16 (tick16),
        .cts    (cts),
        .brk    (brk),
        .clr    (q_clear),
        .empty  (empty),
        .head   (head),
        .fmt    (fmt),
        .pop    (pop),
        .txd    (txd)
    );

    assert_idle_high_R1: assert property (@(posedge clk)
        $past(rst) |-> (txd || brk) && empty && !full);

endmodule

// File: tb/serial_tx_test.sv
`timescale 1ns/1ps
module serial_tx_test;

    localparam int DEPTH = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick16 = 1'b0;
    logic       wr_en = 1'b0;
    logic [11:0] wr_data = '0;
    logic       q_enable = 1'b1;
    logic       q_clear = 1'b0;
    logic       cts = 1'b1;
    logic       brk = 1'b0;
    logic [3:0] word_len = 4'd8;
    logic [2:0] parity_mode = 3'b000;
    logic [8:0] frame_last = 9'd159;
    logic       txd, full, empty;
    logic [3:0] count;

    int tests = 0;
    int fails = 0;
    bit tick_on = 1'b1;
    int tick_div = 0;

    logic [11:0] q[$];
    int          m_busy = 0;
    int          m_cnt = 0;
    logic [11:0] m_char = '0;
    int          m_cap;
    bit          m_wasfull, m_pop;

    serial_tx #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst(rst), .tick16(tick16), .wr_en(wr_en), .wr_data(wr_data),
        .q_enable(q_enable), .q_clear(q_clear), .cts(cts), .brk(brk),
        .word_len(word_len), .parity_mode(parity_mode), .frame_last(frame_last),
        .txd(txd), .full(full), .empty(empty), .count(count)
    );

    always #2.5 clk = ~clk;

    always @(negedge clk) begin
        tick_div = (tick_div + 1) % 4;
        tick16 <= tick_on && tick_div == 0;
    end

    task automatic check(bit ok, string tag, int act, int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
        end
    endtask

    function automatic int exp_line();
        int idx, w, ones;
        if (brk) return 0;
        if (m_busy == 0) return 1;
        idx = m_cnt / 16;
        w = int'(word_len);
        if (idx == 0) return 0;
        if (idx <= w) return int'(m_char[idx-1]);
        if (idx == w + 1 && parity_mode[0]) begin
            ones = 0;
            for (int i = 0; i < w; i++) ones += int'(m_char[i]);
            case (parity_mode[2:1])
                2'b00: return (ones % 2 == 0) ? 1 : 0;
                2'b01: return ones % 2;
                2'b10: return 1;
                default: return 0;
            endcase
        end
        return 1;
    endfunction

    function automatic string line_tag();
        int idx;
        if (brk) return "R7 break";
        if (m_busy == 0) return "R1 idle";
        idx = m_cnt / 16;
        if (idx == 0) return "R2 start";
        if (idx <= int'(word_len)) return "R3 data";
        if (idx == int'(word_len) + 1 && parity_mode[0]) return "R4 parity";
        return "R5 stop";
    endfunction

    // reference model, updated on every rising edge
    always @(posedge clk) begin
        if (rst) begin
            q.delete();
            m_busy = 0;
            m_cnt = 0;
        end else begin
            m_cap = q_enable ? DEPTH : 1;
            m_wasfull = q.size() >= m_cap;
            m_pop = 1'b0;
            if (m_busy == 0) begin
                if (tick16 && q.size() > 0 && cts && !brk && !q_clear) begin
                    m_char = q[0];
                    m_pop = 1'b1;
                    m_busy = 1;
                    m_cnt = 0;
                end
            end else if (tick16) begin
                if (m_cnt == int'(frame_last)) m_busy = 0;
                else m_cnt++;
            end
            if (q_clear) q.delete();
            else begin
                if (m_pop) void'(q.pop_front());
                if (wr_en && !m_wasfull) q.push_back(wr_data);
            end
        end
    end

    // compare every clock, 1 ns after the edge
    always @(posedge clk) begin
        #1;
        check(int'(txd) == exp_line(), line_tag(), int'(txd), exp_line());
        check(int'(full) == ((q.size() >= (q_enable ? DEPTH : 1)) ? 1 : 0),
              q_enable ? "R8 full" : "R9 full", int'(full),
              (q.size() >= (q_enable ? DEPTH : 1)) ? 1 : 0);
        check(int'(empty) == ((q.size() == 0) ? 1 : 0), "R11 empty", int'(empty),
              (q.size() == 0) ? 1 : 0);
        check(int'(count) == q.size(), "R11 count", int'(count), q.size());
    end

    task automatic put(logic [11:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_fmt(int w, logic [2:0] p, int stop_half);
        @(negedge clk);
        word_len = 4'(w);
        parity_mode = p;
        frame_last = 9'((1 + w + int'(p[0])) * 16 + stop_half * 8 - 1);
    endtask

    task automatic drain();
        while (q.size() != 0 || m_busy != 0) @(negedge clk);
        repeat (10) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check(txd === 1'b1, "R1 reset txd", int'(txd), 1);
        check(empty === 1'b1 && full === 1'b0, "R1 reset flags", int'({full, empty}), 1);
        check(count === 4'd0, "R1 reset count", int'(count), 0);
        rst = 1'b0;
        repeat (4) @(negedge clk);

        // R3: 8 data bits, no parity, one stop
        set_fmt(8, 3'b000, 2);
        put(12'h0A5);
        put(12'h03C);
        drain();
        // R4: 5 bits odd parity, one and a half stop
        set_fmt(5, 3'b001, 3);
        put(12'h013);
        put(12'h00E);
        drain();
        // R4: 12 bits even parity, two stop
        set_fmt(12, 3'b011, 4);
        put(12'hABC);
        drain();
        // R4: forced mark and forced space parity
        set_fmt(7, 3'b101, 2);
        put(12'h055);
        drain();
        set_fmt(7, 3'b111, 2);
        put(12'h07F);
        drain();

        // R6 / R8 / R11: hold cts low and fill the queue past its depth
        set_fmt(8, 3'b000, 2);
        cts = 1'b0;
        for (int i = 0; i < 3; i++) put(12'(8'h11 * (i + 1)));
        @(negedge clk);
        check(count == 4'd3, "R11 three held", int'(count), 3);
        for (int i = 3; i < DEPTH + 2; i++) put(12'(8'h11 * (i + 1)));
        repeat (200) @(negedge clk);
        check(full && count == 4'(DEPTH), "R8 full at depth", int'(count), DEPTH);
        check(txd == 1'b1, "R6 no start while cts low", int'(txd), 1);
        // R6: release, then drop cts mid-frame
        cts = 1'b1;
        repeat (250) @(negedge clk);
        cts = 1'b0;
        repeat (900) @(negedge clk);
        check(count == 4'(DEPTH - 1), "R6 one frame only", int'(count), DEPTH - 1);
        // R10: clear empties queue
        @(negedge clk);
        q_clear = 1'b1;
        @(negedge clk);
        q_clear = 1'b0;
        check(count == 4'd0 && empty, "R10 clear", int'(count), 0);
        cts = 1'b1;
        repeat (20) @(negedge clk);

        // R7: break with a queued character, then break mid-frame
        brk = 1'b1;
        put(12'h0C3);
        repeat (300) @(negedge clk);
        check(txd == 1'b0 && count == 4'd1, "R7 hold under break", int'(count), 1);
        brk = 1'b0;
        repeat (200) @(negedge clk);
        brk = 1'b1;
        repeat (120) @(negedge clk);
        brk = 1'b0;
        drain();

        // R9: single holding register mode
        q_enable = 1'b0;
        cts = 1'b0;
        put(12'h0F0);
        put(12'h00F);
        @(negedge clk);
        check(count == 4'd1 && full, "R9 single register", int'(count), 1);
        cts = 1'b1;
        drain();
        check(txd == 1'b1 && empty, "R9 drained", int'(empty), 1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule